// File: doc/BRIEF.md
# I2C Slave Address Matcher with Latched Event Status

This block follows the slave side of an I2C bus. A separate bus monitor hands it one-cycle pulses for START (including repeated START) and STOP, a bus-busy level, and the synchronised SCL and SDA levels. After every START the block shifts in the first byte, MSB first, on the rising SCL edges. It then compares the upper seven bits with a programmed own address and the whole byte with the general-call address.

On a hit the block records that it is addressed, the direction the master asked for, and whether the hit was a general call. It also requests an acknowledge, so that the pad logic pulls SDA low for the ninth clock. Four event bits latch into an interrupt status vector. Software clears them by writing ones. Data bytes that follow the address, and 10-bit addressing, are handled elsewhere.

Top module: `i2c_slave_addr_tracker`

## Requirements
- R1: After reset, `addressed`, `slave_rw`, `gen_call`, `ack_req` and every bit of `irq_status` are 0.
- R2: The byte formed from SDA on the eight rising SCL edges after a START (first bit is bit 7) matches when its bits 7..1 equal `own_addr` and are not all zero. `addressed` is high in the cycle after the eighth rising edge is sampled.
- R3: While `addressed` is high, `slave_rw` equals bit 0 of the matched byte: 1 means the master reads, 0 means the master writes. It is 0 whenever `addressed` is 0.
- R4: The byte 8'h00 is a general call. When `gc_enable` is high it sets both `gen_call` and `addressed`. When `gc_enable` is low it sets neither. The byte 8'h01 never matches.
- R5: A `stop_pulse` or a `start_pulse` clears `addressed`, `slave_rw`, `gen_call` and `ack_req` on the next clock edge.
- R6: `ack_req` rises together with `addressed` on a match. It falls after the first falling SCL edge that follows the ninth rising edge. It never rises on a mismatch.
- R7: The bits of `irq_status` latch on these events: bit 0 on `arb_lost`, bit 1 when `addressed` sets, bit 2 when `addressed` clears, bit 3 when `bus_busy` falls.
- R8: A cycle with `clr_wr` high clears each `irq_status` bit whose `clr_mask` bit is 1. Bits whose mask bit is 0 keep their value. An event in the same cycle leaves its bit set.
- R9: After the acknowledge clock, and after a mismatched address, SCL activity causes no new match and no `ack_req` until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pulse | input | 1 | One-cycle START or repeated START detect |
| stop_pulse | input | 1 | One-cycle STOP detect |
| bus_busy | input | 1 | Bus-busy level from the monitor |
| arb_lost | input | 1 | One-cycle arbitration-lost event |
| scl | input | 1 | Synchronised SCL level |
| sda | input | 1 | Synchronised SDA level |
| own_addr | input | ADDR_W | Programmed 7-bit slave address |
| gc_enable | input | 1 | Allows a response to the general call |
| clr_wr | input | 1 | Write strobe for the interrupt status |
| clr_mask | input | 4 | Write data: ones clear bits |
| addressed | output | 1 | Addressed as slave |
| slave_rw | output | 1 | Direction bit of the matched address |
| gen_call | output | 1 | Addressed by a general call |
| ack_req | output | 1 | Request to pull SDA low for the address acknowledge |
| irq_status | output | 4 | Latched events {bus-not-busy, not-addressed, addressed, arbitration-lost} |

## Verification
A bit counter or phase register that drifts would show up at the ports as `addressed` and `ack_req` rising one SCL edge early or late, or not at all. The per-clock comparison catches this in the very cycle after the eighth rising edge. A flag that fails to clear on a START or STOP differs from the model on the following clock. The same stale flag also leaves bit 2 of `irq_status` unset, so the error stays visible until software writes to the status. A wrong clear mask or a lost event shows in `irq_status` on the edge after the write or the event.

// File: rtl/i2c_sat_pkg.sv
package i2c_sat_pkg;
  localparam int IRQ_W    = 4;
  localparam int IRQ_ARB  = 0;
  localparam int IRQ_AAS  = 1;
  localparam int IRQ_NAAS = 2;
  localparam int IRQ_BNB  = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACK_LO,
    PH_ACK_HI,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/i2c_sat_shift.sv
module i2c_sat_shift
  import i2c_sat_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              scl,
  input  logic              sda,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ack_end
);
  localparam int CNT_W = $clog2(BYTE_W);

  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-2:0]   sh_q, sh_d;
  logic                scl_q;
  logic                scl_rise, scl_fall;
  logic                sh_en, cnt_en, ph_en;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign byte_val = {sh_q, sda};

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    sh_en     = 1'b0;
    byte_done = 1'b0;
    ack_end   = 1'b0;
    if (start_pulse) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
    end else if (stop_pulse) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_ADDR: begin
          if (scl_rise) begin
            sh_en = 1'b1;
            sh_d  = {sh_q[BYTE_W-3:0], sda};
            if (cnt_q == CNT_W'(BYTE_W-1)) begin
              byte_done = 1'b1;
              phase_d   = PH_ACK_LO;
              cnt_d     = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_ACK_LO: if (scl_rise) phase_d = PH_ACK_HI;
        PH_ACK_HI: begin
          if (scl_fall) begin
            ack_end = 1'b1;
            phase_d = PH_HOLD;
          end
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  assign ph_en  = (phase_d != phase_q);
  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      scl_q   <= 1'b1;
    end else begin
      scl_q <= scl;
      if (ph_en)  phase_q <= phase_d;
      if (cnt_en) cnt_q   <= cnt_d;
      if (sh_en)  sh_q    <= sh_d;
    end
  end
endmodule

// File: rtl/i2c_sat_match.sv
module i2c_sat_match #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              byte_done,
  input  logic [ADDR_W:0]   byte_val,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_enable,
  input  logic              ack_end,
  output logic              addressed,
  output logic              slave_rw,
  output logic              gen_call,
  output logic              ack_req,
  output logic              aas_set_ev,
  output logic              aas_clr_ev
);
  logic [ADDR_W-1:0] addr_f;
  logic              own_hit, gc_hit, hit;
  logic              aas_d, rw_d, gc_d, ack_d;
  logic              upd_en;

  assign addr_f  = byte_val[ADDR_W:1];
  assign own_hit = (addr_f == own_addr) && (addr_f != '0);
  assign gc_hit  = (byte_val == '0) && gc_enable;
  assign hit     = byte_done && (own_hit || gc_hit);

  always_comb begin
    aas_d = addressed;
    rw_d  = slave_rw;
    gc_d  = gen_call;
    ack_d = ack_req;
    if (start_pulse || stop_pulse) begin
      aas_d = 1'b0;
      rw_d  = 1'b0;
      gc_d  = 1'b0;
      ack_d = 1'b0;
    end else if (hit) begin
      aas_d = 1'b1;
      rw_d  = byte_val[0];
      gc_d  = gc_hit;
      ack_d = 1'b1;
    end else if (ack_end) begin
      ack_d = 1'b0;
    end
  end

  assign upd_en     = start_pulse | stop_pulse | hit | ack_end;
  assign aas_set_ev = aas_d & ~addressed;
  assign aas_clr_ev = addressed & ~aas_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      slave_rw  <= 1'b0;
      gen_call  <= 1'b0;
      ack_req   <= 1'b0;
    end else if (upd_en) begin
      addressed <= aas_d;
      slave_rw  <= rw_d;
      gen_call  <= gc_d;
      ack_req   <= ack_d;
    end
  end
endmodule

// File: rtl/i2c_sat_irq.sv
module i2c_sat_irq
  import i2c_sat_pkg::*;
#(
  parameter int NBITS = IRQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt,
  input  logic             bus_busy,
  input  logic             clr_wr,
  input  logic [NBITS-1:0] clr_mask,
  output logic [NBITS-1:0] irq_status
);
  logic             bb_q;
  logic [NBITS-1:0] set_vec;

  always_comb begin
    set_vec          = evt;
    set_vec[IRQ_BNB] = evt[IRQ_BNB] | (bb_q & ~bus_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bb_q <= 1'b0;
    else        bb_q <= bus_busy;
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic clr_i, en_i, nxt_i;
    assign clr_i = clr_wr & clr_mask[i];
    assign en_i  = clr_i | set_vec[i];
    assign nxt_i = set_vec[i] | (irq_status[i] & ~clr_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    irq_status[i] <= 1'b0;
      else if (en_i) irq_status[i] <= nxt_i;
    end
  end
endmodule

// File: rtl/i2c_slave_addr_tracker.sv
module i2c_slave_addr_tracker
  import i2c_sat_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              bus_busy,
  input  logic              arb_lost,
  input  logic              scl,
  input  logic              sda,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_enable,
  input  logic              clr_wr,
  input  logic [IRQ_W-1:0]  clr_mask,
  output logic              addressed,
  output logic              slave_rw,
  output logic              gen_call,
  output logic              ack_req,
  output logic [IRQ_W-1:0]  irq_status
);
  localparam int BYTE_W = ADDR_W + 1;

  logic              byte_done, ack_end;
  logic [BYTE_W-1:0] byte_val;
  logic              aas_set_ev, aas_clr_ev;
  logic [IRQ_W-1:0]  evt;

  i2c_sat_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk, .rst_n, .start_pulse, .stop_pulse, .scl, .sda,
    .byte_done, .byte_val, .ack_end
  );

  i2c_sat_match #(.ADDR_W(ADDR_W)) u_match (
    .clk, .rst_n, .start_pulse, .stop_pulse, .byte_done, .byte_val,
    .own_addr, .gc_enable, .ack_end,
    .addressed, .slave_rw, .gen_call, .ack_req, .aas_set_ev, .aas_clr_ev
  );

  always_comb begin
    evt           = '0;
    evt[IRQ_ARB]  = arb_lost;
    evt[IRQ_AAS]  = aas_set_ev;
    evt[IRQ_NAAS] = aas_clr_ev;
  end

  i2c_sat_irq #(.NBITS(IRQ_W)) u_irq (
    .clk, .rst_n, .evt, .bus_busy, .clr_wr, .clr_mask, .irq_status
  );
endmodule

// File: rtl/i2c_sat_checker.sv
module i2c_sat_checker
  import i2c_sat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_pulse,
  input logic             stop_pulse,
  input logic             bus_busy,
  input logic             gc_enable,
  input logic             clr_wr,
  input logic             addressed,
  input logic             slave_rw,
  input logic             gen_call,
  input logic             ack_req,
  input logic [IRQ_W-1:0] irq_status
);
  a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !addressed && !gen_call && !slave_rw);
  a_r5_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !addressed && !gen_call && !slave_rw && !ack_req);
  a_r3_rw_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    slave_rw |-> addressed);
  a_r4_gc_sets_aas: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> addressed);
  a_r4_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_call) |-> $past(gc_enable));
  a_r6_ack_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> addressed);
  a_r7_naas_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addressed) |-> irq_status[IRQ_NAAS]);
  a_r7_bnb_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |=> irq_status[IRQ_BNB]);
  a_r8_no_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((irq_status & $past(irq_status)) == $past(irq_status)));
endmodule

bind i2c_slave_addr_tracker i2c_sat_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .bus_busy(bus_busy), .gc_enable(gc_enable), .clr_wr(clr_wr),
  .addressed(addressed), .slave_rw(slave_rw), .gen_call(gen_call),
  .ack_req(ack_req), .irq_status(irq_status)
);

// File: tb/test_i2c_slave_addr_tracker.sv
module test_i2c_slave_addr_tracker;
  logic clk = 1'b0;
  logic rst_n, start_pulse, stop_pulse, bus_busy, arb_lost, scl, sda;
  logic [6:0] own_addr;
  logic gc_enable, clr_wr;
  logic [3:0] clr_mask;
  logic addressed, slave_rw, gen_call, ack_req;
  logic [3:0] irq_status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  i2c_slave_addr_tracker i_i2c_slave_addr_tracker (
    .clk, .rst_n, .start_pulse, .stop_pulse, .bus_busy, .arb_lost, .scl, .sda,
    .own_addr, .gc_enable, .clr_wr, .clr_mask,
    .addressed, .slave_rw, .gen_call, .ack_req, .irq_status
  );

  // behavioural reference
  int  m_phase;
  bit  m_bits[$];
  bit  m_aas, m_rw, m_gc, m_ack;
  bit  [3:0] m_irq;
  bit  p_scl, p_bb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_bits.delete();
      m_aas = 0; m_rw = 0; m_gc = 0; m_ack = 0; m_irq = 0;
      p_scl = 1; p_bb = 0;
    end else begin
      bit old_aas, rise, fall;
      old_aas = m_aas;
      rise = scl && !p_scl;
      fall = !scl && p_scl;
      if (start_pulse || stop_pulse) begin
        m_phase = start_pulse ? 1 : 0;
        m_bits.delete();
        m_aas = 0; m_rw = 0; m_gc = 0; m_ack = 0;
      end else if (m_phase == 1 && rise) begin
        m_bits.push_back(sda);
        if (m_bits.size() == 8) begin
          int b, a;
          bit gcm, own;
          b = 0;
          foreach (m_bits[k]) b = b * 2 + int'(m_bits[k]);
          a = b / 2;
          gcm = (b == 0) && gc_enable;
          own = (a == int'(own_addr)) && (a != 0);
          if (gcm || own) begin
            m_aas = 1; m_rw = b[0]; m_gc = gcm; m_ack = 1;
          end
          m_phase = 2;
        end
      end else if (m_phase == 2 && rise) begin
        m_phase = 3;
      end else if (m_phase == 3 && fall) begin
        m_phase = 4;
        m_ack = 0;
      end
      if (clr_wr) m_irq = m_irq & ~clr_mask;
      if (arb_lost) m_irq[0] = 1;
      if (!old_aas && m_aas) m_irq[1] = 1;
      if (old_aas && !m_aas) m_irq[2] = 1;
      if (p_bb && !bus_busy) m_irq[3] = 1;
      p_scl = scl;
      p_bb  = bus_busy;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 addressed per-clock", addressed, m_aas);
      chk("R3 slave_rw per-clock", slave_rw, m_rw);
      chk("R4 gen_call per-clock", gen_call, m_gc);
      chk("R6 ack_req per-clock", ack_req, m_ack);
      chk("R7 irq_status per-clock", irq_status, m_irq);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    if (!scl) begin
      @(negedge clk) sda = 1'b1;
      idle(2); scl = 1'b1; idle(2);
    end
    @(negedge clk) begin bus_busy = 1'b1; sda = 1'b0; start_pulse = 1'b1; end
    @(negedge clk) start_pulse = 1'b0;
    idle(2); scl = 1'b0; idle(1);
  endtask

  task automatic do_stop();
    @(negedge clk) sda = 1'b0;
    idle(2); scl = 1'b1; idle(2);
    @(negedge clk) begin sda = 1'b1; stop_pulse = 1'b1; end
    @(negedge clk) stop_pulse = 1'b0;
    idle(3); bus_busy = 1'b0; idle(2);
  endtask

  task automatic clock_bit(bit b);
    @(negedge clk) sda = b;
    idle(2); scl = 1'b1; idle(3); scl = 1'b0; idle(1);
  endtask

  task automatic send_bits(logic [7:0] v);
    for (int i = 7; i >= 0; i--) clock_bit(v[i]);
  endtask

  task automatic w1c(logic [3:0] m);
    @(negedge clk) begin clr_wr = 1'b1; clr_mask = m; end
    @(negedge clk) begin clr_wr = 1'b0; clr_mask = '0; end
  endtask

  initial begin
    rst_n = 0; start_pulse = 0; stop_pulse = 0; bus_busy = 0; arb_lost = 0;
    scl = 1; sda = 1; own_addr = 7'h5A; gc_enable = 0; clr_wr = 0; clr_mask = 0;
    idle(3);
    chk("R1 reset addressed", addressed, 0);
    chk("R1 reset slave_rw", slave_rw, 0);
    chk("R1 reset gen_call", gen_call, 0);
    chk("R1 reset ack_req", ack_req, 0);
    chk("R1 reset irq_status", irq_status, 0);
    @(negedge clk) rst_n = 1;
    idle(2);

    // master write to own address
    do_start();
    send_bits(8'hB4);
    chk("R6 ack_req before ninth clock", ack_req, 1);
    chk("R2 own address match", addressed, 1);
    chk("R3 write direction", slave_rw, 0);
    clock_bit(1'b1);
    chk("R6 ack_req dropped after ninth clock", ack_req, 0);
    chk("R7 addressed event", irq_status, 4'b0010);
    do_stop();
    chk("R5 cleared on stop", addressed, 0);
    chk("R7 not-addressed and bus-not-busy", irq_status, 4'b1110);
    w1c(4'b0100);
    chk("R8 one clears only masked bit", irq_status, 4'b1010);
    w1c(4'b0000);
    chk("R8 zero write keeps bits", irq_status, 4'b1010);
    w1c(4'b1010);
    chk("R8 all cleared", irq_status, 4'b0000);

    // master read, data byte, then repeated start to another address
    do_start();
    send_bits(8'hB5);
    clock_bit(1'b1);
    chk("R3 read direction", slave_rw, 1);
    send_bits(8'hB4);
    chk("R9 data byte gives no ack", ack_req, 0);
    clock_bit(1'b1);
    do_start();
    chk("R5 cleared on repeated start", addressed, 0);
    send_bits(8'h66);
    chk("R9 mismatch no ack", ack_req, 0);
    chk("R9 mismatch not addressed", addressed, 0);
    clock_bit(1'b1);
    do_stop();
    w1c(4'b1111);

    // general call disabled, then enabled
    do_start();
    send_bits(8'h00);
    chk("R4 general call ignored when disabled", gen_call, 0);
    chk("R4 no address when disabled", addressed, 0);
    clock_bit(1'b1);
    gc_enable = 1'b1;
    do_start();
    send_bits(8'h00);
    chk("R4 general call flag", gen_call, 1);
    chk("R4 general call addresses", addressed, 1);
    chk("R4 general call acknowledged", ack_req, 1);
    clock_bit(1'b1);
    do_start();
    chk("R5 gen_call cleared on repeated start", gen_call, 0);
    send_bits(8'h01);
    chk("R4 byte 01 never matches", addressed, 0);
    clock_bit(1'b1);
    do_stop();
    w1c(4'b1111);
    chk("R8 clear after general call", irq_status, 0);

    // arbitration lost, and a clear in the same cycle as an event
    @(negedge clk) arb_lost = 1'b1;
    @(negedge clk) arb_lost = 1'b0;
    chk("R7 arbitration lost latched", irq_status, 4'b0001);
    @(negedge clk) begin arb_lost = 1'b1; clr_wr = 1'b1; clr_mask = 4'b0001; end
    @(negedge clk) begin arb_lost = 1'b0; clr_wr = 1'b0; clr_mask = 4'b0000; end
    chk("R8 event beats clear", irq_status, 4'b0001);
    w1c(4'b0001);
    chk("R8 cleared afterwards", irq_status, 0);
    idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule